// File: doc/BRIEF.md
# Sync Frequency Meter with Linearity Range Select

This block watches the raw horizontal and vertical sync lines of a display input and measures the incoming timing. One vertical period serves as the gate for both measurements. A fixed time base of `CLK_PER_TICK` system clocks (one microsecond at the default settings) times that period. Rising edges of horizontal sync are counted inside the same window. From the two counts it derives the vertical rate in hertz and the horizontal rate in kilohertz. It also reports whether horizontal sync pulses are active-low.

The horizontal rate is mapped to a 3-bit range code that drives a bank of deflection linearity capacitors. The code is uneven: two adjacent frequency bands share one value, and the bits do not count upward. The code changes only when the measurement is qualified as stable, meaning three consecutive windows agree. If vertical sync goes missing for longer than the timeout, the measurement is declared invalid and the code is frozen at its last value.

Top module: `sync_range_meter`

## Requirements
- R1: `vperiod_ticks` holds the number of time-base ticks between the last two consecutive vsync rising edges. One tick is `CLK_PER_TICK` clock cycles. The first vsync edge after reset or after a timeout only opens a window and produces no result.
- R2: `hedges` holds the number of hsync rising edges seen in that same window.
- R3: Both window counters saturate at all-ones instead of wrapping. With `HCNT_W`=10, a window holding more than 1023 hsync edges reports 1023.
- R4: `vfreq_hz` equals `TICK_HZ / vperiod_ticks` and `hfreq_khz` equals `hedges * (TICK_HZ/1000) / vperiod_ticks`, both truncated. Both read 0 while `vperiod_ticks` is 0.
- R5: `hsync_neg` is 1 when hsync was high for more clock cycles than it was low during the last window, and 0 otherwise.
- R6: `meas_stable` rises at the window result that makes three consecutive results agree within ±1 in both the tick count and the edge count. It falls on the first result that differs by more than that.
- R7: `range_sel` (bit 2 written first) is 000 below 36 kHz, 001 from 36 to 39 kHz, 101 from 40 to 61 kHz, and 111 at 62 kHz and above. No other value ever appears.
- R8: `range_sel` is updated only from a stable result and holds its value while `meas_stable` is 0.
- R9: If no vsync rising edge is seen for `TIMEOUT_TICKS` ticks, `meas_valid` and `meas_stable` drop to 0 and `range_sel` keeps its last value.
- R10: After reset every output is 0.
- R11: `meas_valid` rises with the first complete window result, and again with the first result after a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Raw horizontal sync line |
| vsync_in | input | 1 | Raw vertical sync line |
| vperiod_ticks | output | VCNT_W | Ticks in the last vertical period |
| hedges | output | HCNT_W | Hsync rising edges in the last vertical period |
| hsync_neg | output | 1 | Hsync pulses are active-low |
| vfreq_hz | output | FREQ_W | Vertical rate in Hz |
| hfreq_khz | output | KHZ_W | Horizontal rate in kHz |
| range_sel | output | 3 | Linearity capacitor range code |
| meas_valid | output | 1 | A window result is present and vsync is alive |
| meas_stable | output | 1 | Three consecutive results agree |

## Verification
The bench builds the block with `CLK_PER_TICK`=2, `VCNT_W`=16, `HCNT_W`=10 and `TIMEOUT_TICKS`=5000. Vertical periods of 1000 to 1550 ticks therefore last only a few thousand clocks. Each range band, including the shared 40 to 61 kHz band and the 40 kHz boundary, can then be reached with hsync periods that divide the frame exactly. The narrow edge counter lets a two-clock hsync saturate it. The short timeout can be probed on both sides of its limit within the run.

// File: rtl/sync_meter_pkg.sv
package sync_meter_pkg;

   // Band edges in kHz; the code order is fixed by the capacitor bank wiring.
   localparam int unsigned BAND_A_KHZ = 36;
   localparam int unsigned BAND_B_KHZ = 40;
   localparam int unsigned BAND_C_KHZ = 62;

   localparam logic [2:0] SEL_LOWEST = 3'b000;
   localparam logic [2:0] SEL_LOW    = 3'b001;
   localparam logic [2:0] SEL_MID    = 3'b101;
   localparam logic [2:0] SEL_HIGH   = 3'b111;

   function automatic logic [2:0] khz_to_sel(input logic [31:0] khz);
      if (khz < BAND_A_KHZ)      return SEL_LOWEST;
      else if (khz < BAND_B_KHZ) return SEL_LOW;
      else if (khz < BAND_C_KHZ) return SEL_MID;
      else                       return SEL_HIGH;
   endfunction

endpackage

// File: rtl/smr_sync_edge.sv
module smr_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         last  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], din};
         last  <= chain[STAGES-1];
      end
   end

   assign lvl  = chain[STAGES-1];
   assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/smr_timebase.sv
module smr_timebase #(
   parameter int DIV = 12
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (DIV == 1) begin : g_every_clock
         logic unused_ok;
         assign unused_ok = clk ^ rst_n;
         assign tick = 1'b1;
      end else begin : g_divider
         localparam int CW = $clog2(DIV);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  cnt <= '0;
            else if (cnt == CW'(DIV - 1)) cnt <= '0;
            else                         cnt <= cnt + CW'(1);
         end
         assign tick = (cnt == CW'(DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/smr_window_counter.sv
module smr_window_counter #(
   parameter int VCNT_W        = 20,
   parameter int HCNT_W        = 12,
   parameter int POL_W         = 25,
   parameter int TIMEOUT_TICKS = 100000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              v_rise,
   input  logic              h_rise,
   input  logic              h_lvl,
   output logic              win_done,
   output logic [VCNT_W-1:0] win_ticks,
   output logic [HCNT_W-1:0] win_edges,
   output logic              win_neg,
   output logic              lost
);
   localparam int TO_W = $clog2(TIMEOUT_TICKS + 1);

   logic              armed;
   logic [VCNT_W-1:0] tick_acc, tick_nx;
   logic [HCNT_W-1:0] edge_acc, edge_nx;
   logic [POL_W-1:0]  hi_acc, hi_nx, lo_acc, lo_nx;
   logic [TO_W-1:0]   idle;

   always_comb begin
      tick_nx = (tick && tick_acc != '1) ? tick_acc + VCNT_W'(1) : tick_acc;
      edge_nx = (h_rise && edge_acc != '1) ? edge_acc + HCNT_W'(1) : edge_acc;
      hi_nx   = (h_lvl && hi_acc != '1) ? hi_acc + POL_W'(1) : hi_acc;
      lo_nx   = (!h_lvl && lo_acc != '1) ? lo_acc + POL_W'(1) : lo_acc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed     <= 1'b0;
         tick_acc  <= '0;
         edge_acc  <= '0;
         hi_acc    <= '0;
         lo_acc    <= '0;
         idle      <= '0;
         win_done  <= 1'b0;
         win_ticks <= '0;
         win_edges <= '0;
         win_neg   <= 1'b0;
         lost      <= 1'b0;
      end else begin
         win_done <= 1'b0;
         lost     <= 1'b0;
         if (v_rise) begin
            if (armed) begin
               win_done  <= 1'b1;
               win_ticks <= tick_nx;
               win_edges <= edge_nx;
               win_neg   <= (hi_nx > lo_nx);
            end
            armed    <= 1'b1;
            tick_acc <= '0;
            edge_acc <= '0;
            hi_acc   <= '0;
            lo_acc   <= '0;
            idle     <= '0;
         end else begin
            tick_acc <= tick_nx;
            edge_acc <= edge_nx;
            hi_acc   <= hi_nx;
            lo_acc   <= lo_nx;
            if (tick) begin
               if (idle == TO_W'(TIMEOUT_TICKS - 1)) begin
                  idle  <= '0;
                  lost  <= armed;
                  armed <= 1'b0;
               end else begin
                  idle <= idle + TO_W'(1);
               end
            end
         end
      end
   end
endmodule

// File: rtl/smr_freq_calc.sv
module smr_freq_calc #(
   parameter int VCNT_W  = 20,
   parameter int HCNT_W  = 12,
   parameter int TICK_HZ = 1000000,
   parameter int FREQ_W  = 20,
   parameter int KHZ_W   = 12
) (
   input  logic [VCNT_W-1:0] per_ticks,
   input  logic [HCNT_W-1:0] edges,
   output logic [FREQ_W-1:0] vfreq_hz,
   output logic [KHZ_W-1:0]  hfreq_khz
);
   localparam int TPK   = TICK_HZ / 1000;
   localparam int PRODW = HCNT_W + 21;
   localparam int DIV_W = ((PRODW > VCNT_W) ? PRODW : VCNT_W) + 1;

   logic [DIV_W-1:0] den, vq, hq;

   always_comb begin
      den = DIV_W'(per_ticks);
      if (den == '0) begin
         vq = '0;
         hq = '0;
      end else begin
         vq = DIV_W'(TICK_HZ) / den;
         hq = (DIV_W'(edges) * DIV_W'(TPK)) / den;
      end
      vfreq_hz  = (vq > DIV_W'({FREQ_W{1'b1}})) ? '1 : vq[FREQ_W-1:0];
      hfreq_khz = (hq > DIV_W'({KHZ_W{1'b1}}))  ? '1 : hq[KHZ_W-1:0];
   end
endmodule

// File: rtl/smr_qualifier.sv
module smr_qualifier
   import sync_meter_pkg::*;
#(
   parameter int VCNT_W = 20,
   parameter int HCNT_W = 12,
   parameter int KHZ_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              win_done,
   input  logic [VCNT_W-1:0] win_ticks,
   input  logic [HCNT_W-1:0] win_edges,
   input  logic              win_neg,
   input  logic              lost,
   input  logic [KHZ_W-1:0]  hfreq_khz,
   output logic [VCNT_W-1:0] meas_ticks,
   output logic [HCNT_W-1:0] meas_edges,
   output logic              meas_neg,
   output logic              valid,
   output logic              stable,
   output logic [2:0]        range_sel
);
   logic              have_prev, upd_q, close;
   logic [1:0]        agree, agree_nx;
   logic [VCNT_W-1:0] dv;
   logic [HCNT_W-1:0] dh;

   always_comb begin
      dv = (win_ticks > meas_ticks) ? win_ticks - meas_ticks : meas_ticks - win_ticks;
      dh = (win_edges > meas_edges) ? win_edges - meas_edges : meas_edges - win_edges;
      close = have_prev && (dv <= VCNT_W'(1)) && (dh <= HCNT_W'(1));
      if (!close)            agree_nx = 2'd0;
      else if (agree == 2'd2) agree_nx = 2'd2;
      else                   agree_nx = agree + 2'd1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meas_ticks <= '0;
         meas_edges <= '0;
         meas_neg   <= 1'b0;
         valid      <= 1'b0;
         stable     <= 1'b0;
         have_prev  <= 1'b0;
         agree      <= 2'd0;
         upd_q      <= 1'b0;
         range_sel  <= SEL_LOWEST;
      end else begin
         upd_q <= win_done;
         if (lost) begin
            valid     <= 1'b0;
            stable    <= 1'b0;
            have_prev <= 1'b0;
            agree     <= 2'd0;
         end else if (win_done) begin
            meas_ticks <= win_ticks;
            meas_edges <= win_edges;
            meas_neg   <= win_neg;
            valid      <= 1'b1;
            have_prev  <= 1'b1;
            agree      <= agree_nx;
            stable     <= (agree_nx == 2'd2);
         end
         if (upd_q && stable) range_sel <= khz_to_sel(32'(hfreq_khz));
      end
   end
endmodule

// File: rtl/sync_range_meter.sv
module sync_range_meter #(
   parameter int CLK_PER_TICK  = 12,
   parameter int TICK_HZ       = 1000000,
   parameter int VCNT_W        = 20,
   parameter int HCNT_W        = 12,
   parameter int FREQ_W        = 20,
   parameter int KHZ_W         = 12,
   parameter int SYNC_STAGES   = 2,
   parameter int TIMEOUT_TICKS = 100000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hsync_in,
   input  logic              vsync_in,
   output logic [VCNT_W-1:0] vperiod_ticks,
   output logic [HCNT_W-1:0] hedges,
   output logic              hsync_neg,
   output logic [FREQ_W-1:0] vfreq_hz,
   output logic [KHZ_W-1:0]  hfreq_khz,
   output logic [2:0]        range_sel,
   output logic              meas_valid,
   output logic              meas_stable
);
   localparam int POL_W = VCNT_W + $clog2(CLK_PER_TICK + 1) + 1;

   generate
      if (CLK_PER_TICK < 1 || SYNC_STAGES < 2 || TIMEOUT_TICKS < 2 ||
          TICK_HZ < 1000 || TICK_HZ >= (1 << 20) || KHZ_W < 7) begin : g_bad_cfg
         $error("sync_range_meter: illegal parameter set");
      end
   endgenerate

   logic tick, h_lvl, h_rise, v_lvl, v_rise;
   logic win_done, win_neg, lost;
   logic [VCNT_W-1:0] win_ticks;
   logic [HCNT_W-1:0] win_edges;

   smr_timebase #(.DIV(CLK_PER_TICK)) u_tb (.clk(clk), .rst_n(rst_n), .tick(tick));

   smr_sync_edge #(.STAGES(SYNC_STAGES)) u_hs (
      .clk(clk), .rst_n(rst_n), .din(hsync_in), .lvl(h_lvl), .rise(h_rise));
   smr_sync_edge #(.STAGES(SYNC_STAGES)) u_vs (
      .clk(clk), .rst_n(rst_n), .din(vsync_in), .lvl(v_lvl), .rise(v_rise));

   logic unused_vlvl;
   assign unused_vlvl = v_lvl;

   smr_window_counter #(
      .VCNT_W(VCNT_W), .HCNT_W(HCNT_W), .POL_W(POL_W), .TIMEOUT_TICKS(TIMEOUT_TICKS)
   ) u_win (
      .clk(clk), .rst_n(rst_n), .tick(tick), .v_rise(v_rise), .h_rise(h_rise),
      .h_lvl(h_lvl), .win_done(win_done), .win_ticks(win_ticks),
      .win_edges(win_edges), .win_neg(win_neg), .lost(lost));

   smr_freq_calc #(
      .VCNT_W(VCNT_W), .HCNT_W(HCNT_W), .TICK_HZ(TICK_HZ), .FREQ_W(FREQ_W), .KHZ_W(KHZ_W)
   ) u_freq (
      .per_ticks(vperiod_ticks), .edges(hedges), .vfreq_hz(vfreq_hz), .hfreq_khz(hfreq_khz));

   smr_qualifier #(.VCNT_W(VCNT_W), .HCNT_W(HCNT_W), .KHZ_W(KHZ_W)) u_qual (
      .clk(clk), .rst_n(rst_n), .win_done(win_done), .win_ticks(win_ticks),
      .win_edges(win_edges), .win_neg(win_neg), .lost(lost), .hfreq_khz(hfreq_khz),
      .meas_ticks(vperiod_ticks), .meas_edges(hedges), .meas_neg(hsync_neg),
      .valid(meas_valid), .stable(meas_stable), .range_sel(range_sel));
endmodule

// File: rtl/sync_range_meter_chk.sv
module sync_range_meter_chk #(
   parameter int CLK_PER_TICK  = 12,
   parameter int VCNT_W        = 20,
   parameter int SYNC_STAGES   = 2,
   parameter int TIMEOUT_TICKS = 100000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              vsync_in,
   input logic [VCNT_W-1:0] vperiod_ticks,
   input logic [2:0]        range_sel,
   input logic              meas_valid,
   input logic              meas_stable
);
   localparam int LIM  = (TIMEOUT_TICKS + 2) * CLK_PER_TICK + SYNC_STAGES + 4;
   localparam int LW   = $clog2(LIM + 1);

   logic [LW-1:0] since_v;
   logic          v_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_v <= '0;
         v_prev  <= 1'b0;
      end else begin
         v_prev <= vsync_in;
         if (vsync_in && !v_prev)      since_v <= '0;
         else if (since_v != LW'(LIM)) since_v <= since_v + LW'(1);
      end
   end

   p_range_code_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (range_sel == 3'b000) || (range_sel == 3'b001) ||
      (range_sel == 3'b101) || (range_sel == 3'b111));

   p_range_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !meas_stable |=> $stable(range_sel));

   p_stable_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      meas_stable |-> meas_valid);

   p_valid_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
      meas_valid |-> (vperiod_ticks != '0));

   p_timeout_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (since_v == LW'(LIM)) |-> !meas_valid);
endmodule

bind sync_range_meter sync_range_meter_chk #(
   .CLK_PER_TICK(CLK_PER_TICK), .VCNT_W(VCNT_W),
   .SYNC_STAGES(SYNC_STAGES), .TIMEOUT_TICKS(TIMEOUT_TICKS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .vperiod_ticks(vperiod_ticks),
   .range_sel(range_sel), .meas_valid(meas_valid), .meas_stable(meas_stable));

// File: tb/sync_range_meter_tb.sv
module sync_range_meter_tb;
   localparam int CPT    = 2;
   localparam int VW     = 16;
   localparam int HW     = 10;
   localparam int FW     = 20;
   localparam int KW     = 12;
   localparam int TO     = 5000;
   localparam int NVEC   = 6;
   localparam int HMAX   = (1 << HW) - 1;

   // frame ticks, hsync period (clocks), pulse width, active-low
   localparam int VEC_V  [NVEC] = '{1000, 1100, 1000, 1000, 1550, 1100};
   localparam int VEC_P  [NVEC] = '{ 100,   55,   50,   40,   31,    2};
   localparam int VEC_PW [NVEC] = '{  10,    6,    5,    4,    3,    1};
   localparam int VEC_N  [NVEC] = '{   0,    1,    0,    1,    0,    0};

   logic clk = 1'b0, rst_n = 1'b0, hsync_in = 1'b0, vsync_in = 1'b0;
   logic [VW-1:0] vperiod_ticks;
   logic [HW-1:0] hedges;
   logic          hsync_neg, meas_valid, meas_stable;
   logic [FW-1:0] vfreq_hz;
   logic [KW-1:0] hfreq_khz;
   logic [2:0]    range_sel;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sync_range_meter #(
      .CLK_PER_TICK(CPT), .TICK_HZ(1000000), .VCNT_W(VW), .HCNT_W(HW),
      .FREQ_W(FW), .KHZ_W(KW), .SYNC_STAGES(2), .TIMEOUT_TICKS(TO)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
      .vperiod_ticks(vperiod_ticks), .hedges(hedges), .hsync_neg(hsync_neg),
      .vfreq_hz(vfreq_hz), .hfreq_khz(hfreq_khz), .range_sel(range_sel),
      .meas_valid(meas_valid), .meas_stable(meas_stable));

   function automatic int sel_of(input int khz);
      if (khz < 36) return 0;
      if (khz < 40) return 1;
      if (khz < 62) return 5;
      return 7;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic run_frames(input int v, input int p, input int pw, input int neg, input int n);
      for (int f = 0; f < n; f++) begin
         for (int i = 0; i < 2 * v; i++) begin
            @(negedge clk);
            vsync_in <= (i < 20);
            hsync_in <= (neg != 0) ^ ((i % p) < pw);
         end
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         vsync_in <= 1'b0;
         hsync_in <= ((i % 100) < 10);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      // R10 reset state
      check("R10 vperiod", int'(vperiod_ticks), 0);
      check("R10 hedges", int'(hedges), 0);
      check("R10 valid", int'(meas_valid), 0);
      check("R10 stable", int'(meas_stable), 0);
      check("R10 range", int'(range_sel), 0);
      check("R10 freq", int'(vfreq_hz) + int'(hfreq_khz), 0);

      for (int k = 0; k < NVEC; k++) begin
         int hc, hf;
         hc = (2 * VEC_V[k]) / VEC_P[k];
         if (hc > HMAX) hc = HMAX;
         hf = (hc * 1000) / VEC_V[k];
         run_frames(VEC_V[k], VEC_P[k], VEC_PW[k], VEC_N[k], 5);
         check("R1 vperiod", int'(vperiod_ticks), VEC_V[k]);
         check("R2/R3 hedges", int'(hedges), hc);
         check("R4 vfreq", int'(vfreq_hz), 1000000 / VEC_V[k]);
         check("R4 hfreq", int'(hfreq_khz), hf);
         check("R5 polarity", int'(hsync_neg), VEC_N[k]);
         check("R6 stable", int'(meas_stable), 1);
         check("R7 range", int'(range_sel), sel_of(hf));
         check("R11 valid", int'(meas_valid), 1);
      end

      // R8: mode change, code held until stable again
      run_frames(1000, 100, 10, 0, 2);
      check("R6 unstable after change", int'(meas_stable), 0);
      check("R8 range held", int'(range_sel), 7);
      run_frames(1000, 100, 10, 0, 3);
      check("R6 stable again", int'(meas_stable), 1);
      check("R8 range updated", int'(range_sel), 0);

      // R6: +-1 jitter still qualifies as stable
      for (int j = 0; j < 6; j++) run_frames(((j % 2) == 0) ? 1000 : 1001, 40, 4, 0, 1);
      check("R6 jitter stable", int'(meas_stable), 1);
      check("R7 jitter range", int'(range_sel), 5);

      // R9: timeout window
      idle(7000);
      check("R9 before limit", int'(meas_valid), 1);
      idle(3000);
      check("R9 valid dropped", int'(meas_valid), 0);
      check("R9 stable dropped", int'(meas_stable), 0);
      check("R9 range held", int'(range_sel), 5);

      // R11: recovery after timeout
      run_frames(1000, 25, 3, 0, 1);
      check("R11 no result on arming edge", int'(meas_valid), 0);
      run_frames(1000, 25, 3, 0, 4);
      check("R11 valid again", int'(meas_valid), 1);
      check("R7 high band", int'(range_sel), 7);
      check("R2 hedges after recovery", int'(hedges), 80);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule